// File: doc/BRIEF.md
# Table-Interpolated Reciprocal Divider

This block divides an unsigned numerator by a normalised unsigned denominator in a fixed number of cycles, without iteration. The high-order bits of the denominator pick an entry from a coarse table of reciprocals and from a matching table of per-step slopes. The low-order bits of the denominator scale the slope into a correction, and that correction is subtracted from the coarse reciprocal. The numerator is then multiplied by the refined reciprocal and rounded to give the quotient.

One operand pair can enter on every clock. Each result leaves a fixed number of cycles later, marked by an output valid. The caller is expected to present a denominator whose top bit is set. A denominator that breaks this rule, zero included, is reported by an error flag that travels with the result. Both tables are computed at elaboration from the width parameters.

With the default parameters, numerator and denominator are 17 bits and the quotient is 16 bits. The result approximates N·2^15/D.

Top module: `rdiv_top`

## Requirements
- R1: For a denominator with bit 16 set, the quotient is within ±1 of round-half-up(N·2^15/D). If that value exceeds 65535, it is first clamped to 65535.
- R2: A result appears on `out_valid` exactly 5 clock cycles after its operands were taken with `in_valid` high. Results leave in the order the operands entered.
- R3: Operand pairs presented on consecutive cycles are all accepted. Their results leave on consecutive cycles, with no stall.
- R4: When the exact quotient exceeds 65535, the output is 0xFFFF (all ones) and `out_err` stays 0.
- R5: A denominator with bit 16 clear (zero included) gives a quotient of 0xFFFF with `out_err` = 1. A denominator with bit 16 set always gives `out_err` = 0.
- R6: While `rst_n` is low, and on the first clock after it, `out_valid` and `out_err` are 0. `out_err` is never 1 unless `out_valid` is 1.
- R7: A cycle with `in_valid` low produces no result. `out_valid` is only high for operands that were accepted.
- R8: For D = 0x10000 (the first table point, with offset bits 5:0 zero), the quotient is exactly (N+1)>>1, with no approximation error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_num | input | 17 | Unsigned numerator |
| in_den | input | 17 | Unsigned denominator. Bit 16 is expected set; bits 15:6 address the tables and bits 5:0 are the interpolation offset |
| out_valid | output | 1 | Result present this cycle |
| out_quot | output | 16 | Rounded quotient, or all ones on saturation or error |
| out_err | output | 1 | Denominator was not normalised; qualified by out_valid |

## Verification
The bench builds two instances. The first uses the default 17-bit widths with a 10-bit table address. It receives boundary operands: interval edges, table endpoints, the largest numerator, and zero and unnormalised denominators. It also receives a long random stream with gaps in `in_valid`. The second instance uses 9-bit operands and a 5-bit table address, which makes it practical to sweep every normalised numerator/denominator pair back to back. That sweep covers every table interval, every interpolation offset and every saturating corner against exact integer division.

// File: rtl/rdiv_pkg.sv
// rdiv_pkg: constant functions that fill the reciprocal and slope tables.
// Assumes dw <= 21, so that every intermediate value fits in 64 bits.
package rdiv_pkg;

    // Rounded 2^(2dw-1)/d0, where d0 is the lower edge of interval idx.
    function automatic logic [63:0] recip_entry(input int dw, input int aw, input int idx);
        logic [63:0] d0;
        logic [63:0] scale;
        d0    = (64'd1 << (dw - 1)) + (64'(idx) << (dw - 1 - aw));
        scale = 64'd1 << (2 * dw - 1);
        return (scale + (d0 >> 1)) / d0;
    endfunction

    // Magnitude of the chord slope per unit of offset across interval idx,
    // scaled by 2^(dw-1). This equals 2^(3dw-2) / (d0*d1), rounded.
    function automatic logic [63:0] slope_entry(input int dw, input int aw, input int idx);
        logic [63:0] d0;
        logic [63:0] d1;
        logic [63:0] prod;
        logic [63:0] scale;
        d0    = (64'd1 << (dw - 1)) + (64'(idx) << (dw - 1 - aw));
        d1    = d0 + (64'd1 << (dw - 1 - aw));
        prod  = d0 * d1;
        scale = 64'd1 << (3 * dw - 2);
        return (scale + (prod >> 1)) / prod;
    endfunction

endpackage

// File: rtl/rdiv_delay.sv
// rdiv_delay: fixed-depth register chain that keeps side data aligned with
// the arithmetic pipeline. It assumes DEPTH >= 1. All stages clear on reset.
module rdiv_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage [DEPTH];

    // Shift the chain by one position per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d_i;
            for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
    end

    assign q_o = stage[DEPTH-1];
endmodule

// File: rtl/rdiv_tables.sv
// rdiv_tables: two elaboration-time tables, the coarse reciprocal and the
// slope magnitude, both read through one output register.
// Assumes the address is the denominator field just below its leading one.
module rdiv_tables #(
    parameter int DEN_W  = 17,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DEN_W:0]    rec_o,
    output logic [DEN_W:0]    slp_o
);
    localparam int TAB_W = DEN_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [TAB_W-1:0] rec_rom [DEPTH];
    logic [TAB_W-1:0] slp_rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign rec_rom[i] = TAB_W'(rdiv_pkg::recip_entry(DEN_W, ADDR_W, i));
        assign slp_rom[i] = TAB_W'(rdiv_pkg::slope_entry(DEN_W, ADDR_W, i));
    end

    // Registered read of both tables; this is pipeline stage 1.
    always_ff @(posedge clk) begin
        rec_o <= rec_rom[addr_i];
        slp_o <= slp_rom[addr_i];
    end
endmodule

// File: rtl/rdiv_correct.sv
// rdiv_correct: stage 2 multiplies the offset by the slope. Stage 3 rounds
// the product down by the slope scaling and subtracts it from the coarse
// reciprocal. Assumes the correction never exceeds the coarse value.
module rdiv_correct #(
    parameter int DEN_W  = 17,
    parameter int ADDR_W = 10
) (
    input  logic                        clk,
    input  logic [DEN_W:0]              rec_i,
    input  logic [DEN_W:0]              slp_i,
    input  logic [DEN_W-2-ADDR_W:0]     off_i,
    output logic [DEN_W:0]              recc_o
);
    localparam int TAB_W = DEN_W + 1;
    localparam int OFF_W = DEN_W - 1 - ADDR_W;
    localparam int FR    = DEN_W - 1;
    localparam int PW    = OFF_W + TAB_W + 1;

    logic [OFF_W+TAB_W-1:0] prod_q;
    logic [TAB_W-1:0]       rec_d;
    logic [PW-1:0]          corr_rnd;

    // Stage 2: correction product, with the coarse reciprocal kept aligned.
    always_ff @(posedge clk) begin
        prod_q <= (OFF_W+TAB_W)'(off_i) * (OFF_W+TAB_W)'(slp_i);
        rec_d  <= rec_i;
    end

    // Round the scaled correction to integer reciprocal units.
    always_comb corr_rnd = ({1'b0, prod_q} + (PW'(1) << (FR - 1))) >> FR;

    // Stage 3: subtract the correction, since the curve falls with D.
    always_ff @(posedge clk) begin
        recc_o <= rec_d - corr_rnd[TAB_W-1:0];
    end
endmodule

// File: rtl/rdiv_scale.sv
// rdiv_scale: stage 4 multiplies the numerator by the refined reciprocal.
// Stage 5 rounds half up, clamps to the quotient width, and forces all ones
// for a flagged denominator. Assumes bad_i arrives aligned with stage 5.
module rdiv_scale #(
    parameter int DEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEN_W-1:0] num_i,
    input  logic [DEN_W:0]   recc_i,
    input  logic             bad_i,
    output logic [DEN_W-2:0] quot_o,
    output logic             err_o
);
    localparam int QUOT_W = DEN_W - 1;
    localparam int PW     = 2 * DEN_W + 1;
    localparam int SH     = DEN_W + 1;

    logic [PW-1:0]    prod_q;
    logic [PW-1:0]    shifted;
    logic [DEN_W-1:0] qfull;

    // Stage 4: full-width product of numerator and reciprocal.
    always_ff @(posedge clk) begin
        prod_q <= PW'(num_i) * PW'(recc_i);
    end

    // Round half up and drop the fraction.
    always_comb begin
        shifted = (prod_q + (PW'(1) << (SH - 1))) >> SH;
        qfull   = shifted[DEN_W-1:0];
    end

    // Stage 5: clamp, force all ones on error, register the flag.
    always_ff @(posedge clk) begin
        if (bad_i || qfull[DEN_W-1]) quot_o <= '1;
        else                         quot_o <= qfull[QUOT_W-1:0];
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= bad_i;
    end
endmodule

// File: rtl/rdiv_top.sv
// rdiv_top: five-stage pipelined divider. It accepts one operand pair per
// clock and returns round(N*2^(DEN_W-2)/D). It assumes the caller presents a
// denominator with its top bit set; any other denominator is flagged.
module rdiv_top #(
    parameter int DEN_W  = 17,
    parameter int ADDR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DEN_W-1:0] in_num,
    input  logic [DEN_W-1:0] in_den,
    output logic             out_valid,
    output logic [DEN_W-2:0] out_quot,
    output logic             out_err
);
    localparam int TAB_W = DEN_W + 1;
    localparam int OFF_W = DEN_W - 1 - ADDR_W;
    localparam int LAT   = 5;

    logic             bad_in;
    logic [TAB_W-1:0] rec_s1;
    logic [TAB_W-1:0] slp_s1;
    logic [OFF_W-1:0] off_s1;
    logic [TAB_W-1:0] recc_s3;
    logic [DEN_W-1:0] num_s3;
    logic             bad_s4;

    // Flag operands whose denominator lacks its leading one.
    always_comb bad_in = in_valid & ~in_den[DEN_W-1];

    rdiv_tables #(.DEN_W(DEN_W), .ADDR_W(ADDR_W)) u_tables (
        .clk    (clk),
        .addr_i (in_den[DEN_W-2 -: ADDR_W]),
        .rec_o  (rec_s1),
        .slp_o  (slp_s1)
    );

    rdiv_delay #(.W(OFF_W), .DEPTH(1)) u_off_dly (
        .clk(clk), .rst_n(rst_n), .d_i(in_den[OFF_W-1:0]), .q_o(off_s1)
    );

    rdiv_correct #(.DEN_W(DEN_W), .ADDR_W(ADDR_W)) u_correct (
        .clk    (clk),
        .rec_i  (rec_s1),
        .slp_i  (slp_s1),
        .off_i  (off_s1),
        .recc_o (recc_s3)
    );

    rdiv_delay #(.W(DEN_W), .DEPTH(3)) u_num_dly (
        .clk(clk), .rst_n(rst_n), .d_i(in_num), .q_o(num_s3)
    );

    rdiv_delay #(.W(1), .DEPTH(LAT-1)) u_bad_dly (
        .clk(clk), .rst_n(rst_n), .d_i(bad_in), .q_o(bad_s4)
    );

    rdiv_delay #(.W(1), .DEPTH(LAT)) u_vld_dly (
        .clk(clk), .rst_n(rst_n), .d_i(in_valid), .q_o(out_valid)
    );

    rdiv_scale #(.DEN_W(DEN_W)) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .num_i  (num_s3),
        .recc_i (recc_s3),
        .bad_i  (bad_s4),
        .quot_o (out_quot),
        .err_o  (out_err)
    );
endmodule

// File: rtl/rdiv_checker.sv
// rdiv_checker: temporal properties of rdiv_top, attached through bind.
// It keeps its own record of accepted operands so that the pipeline outputs
// can be compared with the inputs that produced them.
module rdiv_checker #(
    parameter int DEN_W = 17
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [DEN_W-1:0] in_den,
    input logic             out_valid,
    input logic [DEN_W-2:0] out_quot,
    input logic             out_err
);
    localparam int LAT = 5;

    logic [LAT-1:0] vld_hist;
    logic [LAT-1:0] bad_hist;

    // Record valid and bad-denominator history since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_hist <= '0;
            bad_hist <= '0;
        end else begin
            vld_hist <= {vld_hist[LAT-2:0], in_valid};
            bad_hist <= {bad_hist[LAT-2:0], in_valid & ~in_den[DEN_W-1]};
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_hist[LAT-1]);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_hist[LAT-1] |-> !out_valid);

    assert_err_tracks_den_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err == bad_hist[LAT-1]);

    assert_err_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_quot == '1));

    assert_err_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_valid);
endmodule

bind rdiv_top rdiv_checker #(.DEN_W(DEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_den    (in_den),
    .out_valid (out_valid),
    .out_quot  (out_quot),
    .out_err   (out_err)
);

// File: tb/tb_rdiv_top.sv
// tb_rdiv_top: checks a default-width instance with boundary and random
// operands, and a narrow instance with an exhaustive sweep. Every output is
// compared against exact integer division computed here.
module tb_rdiv_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  BW = 17;
    localparam int  SW = 9;
    localparam int  LAT = 5;
    localparam longint WD_LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic          b_iv = 1'b0;
    logic [BW-1:0] b_n = '0, b_d = '0;
    logic          b_ov, b_err;
    logic [BW-2:0] b_q;

    logic          s_iv = 1'b0;
    logic [SW-1:0] s_n = '0, s_d = '0;
    logic          s_ov, s_err;
    logic [SW-2:0] s_q;

    longint cyc = 0;
    int     nchk = 0;
    int     nfail = 0;
    longint s_outs = 0;
    bit     s_count_on = 1'b0;

    longint bq_n[$], bq_d[$], bq_c[$];
    longint sq_n[$], sq_d[$], sq_c[$];

    rdiv_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .in_num(b_n), .in_den(b_d),
        .out_valid(b_ov), .out_quot(b_q), .out_err(b_err)
    );

    rdiv_top #(.DEN_W(SW), .ADDR_W(5)) dut_small (
        .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .in_num(s_n), .in_den(s_d),
        .out_valid(s_ov), .out_quot(s_q), .out_err(s_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Compare one result with exact division for width dw.
    task automatic score(input int dw, input longint n, input longint d, input longint cin,
                         input longint q, input bit e);
        longint maxq, exact, ref_v, diff;
        maxq = (longint'(1) << (dw - 1)) - 1;
        check(cyc - cin == LAT, "R2 latency", cyc - cin, LAT);
        if (((d >> (dw - 1)) & 1) == 0) begin
            check(q == maxq, "R5 bad denominator quotient", q, maxq);
            check(e == 1'b1, "R5 bad denominator flag", e, 1);
        end else begin
            check(e == 1'b0, "R5 flag low for normalised denominator", e, 0);
            exact = (n * (longint'(1) << (dw - 2)) + d / 2) / d;
            ref_v = (exact > maxq) ? maxq : exact;
            diff  = q - ref_v;
            if (exact > maxq)
                check(diff >= -1 && diff <= 1, "R4 saturation", q, ref_v);
            else
                check(diff >= -1 && diff <= 1, "R1 accuracy", q, ref_v);
            if (d == (longint'(1) << (dw - 1)))
                check(q == ref_v, "R8 exact at first table point", q, ref_v);
        end
    endtask

    // Scoreboard: sample outputs between clock edges.
    always @(negedge clk) begin
        if (rst_n && b_ov) begin
            if (bq_n.size() == 0) check(1'b0, "R7 unexpected output", 1, 0);
            else score(BW, bq_n.pop_front(), bq_d.pop_front(), bq_c.pop_front(), longint'(b_q), b_err);
        end
        if (rst_n && s_ov) begin
            if (s_count_on) s_outs++;
            if (sq_n.size() == 0) check(1'b0, "R7 unexpected output", 1, 0);
            else score(SW, sq_n.pop_front(), sq_d.pop_front(), sq_c.pop_front(), longint'(s_q), s_err);
        end
    end

    task automatic drive_b(input bit v, input longint n, input longint d);
        b_iv = v; b_n = BW'(n); b_d = BW'(d);
        if (v) begin bq_n.push_back(n); bq_d.push_back(d); bq_c.push_back(cyc); end
        @(negedge clk);
    endtask

    task automatic drive_s(input bit v, input longint n, input longint d);
        s_iv = v; s_n = SW'(n); s_d = SW'(d);
        if (v) begin sq_n.push_back(n); sq_d.push_back(d); sq_c.push_back(cyc); end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    initial begin : watchdog
        wait (cyc >= WD_LIMIT);
        check(1'b0, "watchdog expired", cyc, WD_LIMIT);
        finish_run();
    end

    initial begin : stimulus
        longint nb[8];
        longint db[12];
        longint n, d;
        nb = '{0, 1, 2, 3, 65535, 65536, 131070, 131071};
        db = '{65536, 65537, 65599, 65600, 65601, 98304, 131008, 131071,
               0, 1, 65535, 12345};

        // R6: reset state, and the first clock after release.
        repeat (4) begin
            @(negedge clk);
            check(b_ov == 1'b0 && s_ov == 1'b0, "R6 valid low in reset", b_ov, 0);
            check(b_err == 1'b0 && s_err == 1'b0, "R6 error low in reset", b_err, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(b_ov == 1'b0 && b_err == 1'b0, "R6 quiet after reset", b_ov, 0);

        // R1 R4 R5 R8: boundary grid on the default instance.
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 12; j++)
                drive_b(1'b1, nb[i], db[j]);

        // R7: idle cycles produce nothing once the pipeline drains.
        repeat (LAT + 2) drive_b(1'b0, 0, 0);
        repeat (6) begin
            check(b_ov == 1'b0, "R7 idle output", b_ov, 0);
            drive_b(1'b0, 0, 0);
        end

        // R1 R2 R7: random operands with gaps in valid.
        for (int k = 0; k < 20000; k++) begin
            n = longint'($urandom & 32'h1FFFF);
            d = longint'($urandom & 32'h1FFFF);
            if (($urandom & 15) != 0) d = d | 65536;
            drive_b(($urandom % 5) != 0, n, d);
        end
        drive_b(1'b0, 0, 0);

        // R1 R3 R4 R8: exhaustive back-to-back sweep on the narrow instance.
        s_count_on = 1'b1;
        for (int dd = 256; dd < 512; dd++)
            for (int nn = 0; nn < 512; nn++)
                drive_s(1'b1, nn, dd);
        // R5: unnormalised denominators, zero included.
        for (int nn = 0; nn < 512; nn += 73) begin
            drive_s(1'b1, nn, 0);
            drive_s(1'b1, nn, 1);
            drive_s(1'b1, nn, 255);
        end
        repeat (LAT + 4) drive_s(1'b0, 0, 0);

        // R3: every back-to-back operand produced one result, without stall.
        check(s_outs == 131072 + 24, "R3 back-to-back result count", s_outs, 131072 + 24);
        check(bq_n.size() == 0 && sq_n.size() == 0, "R7 no missing outputs",
              bq_n.size() + sq_n.size(), 0);
        finish_run();
    end
endmodule